// File: doc/BRIEF.md
# Real-time clock with snapshot transfer buffer

This block keeps time of day and calendar date in BCD and gives software a consistent view of them through a set of eight buffer bytes. Software reaches the block over a plain parallel bus: each bus cycle opens with a one-clock start pulse, carries any number of byte reads or writes, and closes with a one-clock end pulse. When a cycle opens, the running counters are photographed into the buffer. Reads of the timekeeping addresses then return that photograph, so the bytes of one cycle always agree with each other even if a tick arrives mid-cycle.

A power-fail pulse photographs the counters as well and raises a hold flag. While the flag is up, the buffer is not refreshed, so the moment of power loss can still be read after power returns. Only software can lower the flag. A write to any timekeeping address copies the whole buffer back into the counters at the end of the cycle, and restarts the prescaler that makes the 100 Hz tick. If the hold flag is still up, the stale snapshot bytes are copied back together with the new byte. Software should therefore clear the flag before setting the time.

Top module: `rtc_xfer_core`

## Requirements
- R1: After reset, addresses 00h..07h read 00,00,00,00,01,01,01,00 (hundredths, seconds, minutes, hours, day of week, date, month, year), and addresses 08h..1Fh read 00h, including the hold flag at bit 6 of 0Ch.
- R2: The hundredths counter advances once every CLK_PER_TICK clocks. Counting starts from the clock edge that ends the most recent load of the counters, or from the release of reset.
- R3: Counters roll over at BCD limits: hundredths 99, seconds 59, minutes 59, hours 23, then 00. Day of week runs 1..7 and returns to 1. Year 99 returns to 00.
- R4: Date rolls to 01 after the last day of the month: 30 days for months 04, 06, 09 and 11, 31 for the other months, and 29 for month 02 when the year is divisible by 4 (00..99), otherwise 28.
- R5: On a start pulse with the hold flag clear, the buffer captures the counter values from before that edge. Reads of 00h..07h return the buffer.
- R6: A power-fail pulse copies the counters into the buffer and sets the hold flag (0Ch bit 6 reads 1).
- R7: While the hold flag is set, reads of 00h..07h keep returning the same snapshot. The flag changes only on a power-fail pulse or a bus write to 0Ch. Once it is cleared, reads follow live time.
- R8: At the end pulse of a cycle that wrote any of 00h..07h, all eight buffer bytes load the counters. With the hold flag set, the frozen bytes load together with the newly written byte.
- R9: That same end pulse restarts the prescaler. Cycles that write only 08h..1Fh leave the prescaler and the counters untouched.
- R10: Addresses 08h..1Fh are byte storage that reads back what was written. At 0Ch, bit 6 is the hold flag and the other bits are storage.
- R11: Read data is 00h whenever the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_fail | input | 1 | One-clock power-fail pulse |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from addressed register |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_start | input | 1 | Cycle-open pulse |
| bus_end | input | 1 | Cycle-close pulse |

## Verification
The bench sets times just short of hour, day, month and year boundaries, including February in leap and non-leap years. It then reads after a random wait. A design with a wrong month length or a bad BCD carry returns a date one step off. Single-byte writes made at random prescaler phases expose a design that forgets to restart the divider, because it would gain or lose a hundredth, and a design that loads only the written byte, because it would not lose the ticks that elapsed during the cycle. The stale-snapshot corner writes seconds while the hold flag is set and then clears the flag. A design that merged the byte into live time, or kept refreshing a frozen buffer, reports a different time than the power-fail moment with the new seconds.

// File: rtl/rtc_xfer_pkg.sv
package rtc_xfer_pkg;

    typedef struct packed {
        logic [7:0] yr;
        logic [7:0] mon;
        logic [7:0] date;
        logic [7:0] dow;
        logic [7:0] hr;
        logic [7:0] min;
        logic [7:0] sec;
        logic [7:0] hund;
    } rtc_time_t;

    localparam int NUM_TK   = 8;
    localparam int NUM_ADDR = 32;
    localparam int AW       = $clog2(NUM_ADDR);
    localparam int TKW      = $clog2(NUM_TK);
    localparam int STORE_N  = NUM_ADDR - NUM_TK;
    localparam int HOLD_BIT = 6;

    localparam logic [AW-1:0] TK_LIMIT  = AW'(NUM_TK);
    localparam logic [AW-1:0] HOLD_ADDR = AW'(12);

    localparam rtc_time_t RTC_EPOCH = '{yr: 8'h00, mon: 8'h01, date: 8'h01,
                                        dow: 8'h01, hr: 8'h00, min: 8'h00,
                                        sec: 8'h00, hund: 8'h00};

    function automatic logic [7:0] bcd_up(input logic [7:0] v);
        return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
    endfunction

    // {rolled, next}: rolls to bottom once v reaches top
    function automatic logic [8:0] wrap_up(input logic [7:0] v,
                                           input logic [7:0] top,
                                           input logic [7:0] bottom);
        return (v >= top) ? {1'b1, bottom} : {1'b0, bcd_up(v)};
    endfunction

    function automatic logic [7:0] month_len(input logic [7:0] mon,
                                             input logic [7:0] yr);
        logic [6:0] ybin;
        ybin = 7'(yr[7:4]) * 7'd10 + 7'(yr[3:0]);
        case (mon)
            8'h02:                      return (ybin[1:0] == 2'd0) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int CLK_PER_TICK = 100000,
    localparam int PW = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    output logic          tick,
    output logic [PW-1:0] cnt
);
    localparam logic [PW-1:0] LAST = PW'(CLK_PER_TICK - 1);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = (st_q.cnt == LAST) && !clr;
        if (clr || st_q.cnt == LAST) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;
endmodule

// File: rtl/rtc_tk_counter.sv
module rtc_tk_counter
    import rtc_xfer_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      load,
    input  rtc_time_t load_val,
    output rtc_time_t now
);
    typedef struct packed {
        rtc_time_t t;
    } ctr_state_t;

    ctr_state_t st_d, st_q;
    logic [8:0] r_hund, r_sec, r_min, r_hr, r_dow, r_date, r_mon, r_yr;
    logic       day_c;

    always_comb begin
        r_hund = wrap_up(st_q.t.hund, 8'h99, 8'h00);
        r_sec  = wrap_up(st_q.t.sec,  8'h59, 8'h00);
        r_min  = wrap_up(st_q.t.min,  8'h59, 8'h00);
        r_hr   = wrap_up(st_q.t.hr,   8'h23, 8'h00);
        r_dow  = wrap_up(st_q.t.dow,  8'h07, 8'h01);
        r_date = wrap_up(st_q.t.date, month_len(st_q.t.mon, st_q.t.yr), 8'h01);
        r_mon  = wrap_up(st_q.t.mon,  8'h12, 8'h01);
        r_yr   = wrap_up(st_q.t.yr,   8'h99, 8'h00);
        day_c  = r_hund[8] & r_sec[8] & r_min[8] & r_hr[8];

        st_d = st_q;
        if (load) begin
            st_d.t = load_val;
        end else if (tick) begin
            st_d.t.hund = r_hund[7:0];
            if (r_hund[8])                       st_d.t.sec  = r_sec[7:0];
            if (r_hund[8] & r_sec[8])            st_d.t.min  = r_min[7:0];
            if (r_hund[8] & r_sec[8] & r_min[8]) st_d.t.hr   = r_hr[7:0];
            if (day_c) begin
                st_d.t.dow  = r_dow[7:0];
                st_d.t.date = r_date[7:0];
            end
            if (day_c & r_date[8])               st_d.t.mon  = r_mon[7:0];
            if (day_c & r_date[8] & r_mon[8])    st_d.t.yr   = r_yr[7:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.t <= RTC_EPOCH;
        end else begin
            st_q <= st_d;
        end
    end

    assign now = st_q.t;
endmodule

// File: rtl/rtc_xfer_regs.sv
module rtc_xfer_regs
    import rtc_xfer_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_fail,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    input  logic          rd,
    input  logic          wr,
    input  logic          cyc_start,
    input  logic          cyc_end,
    input  rtc_time_t     live,
    output logic [7:0]    rdata,
    output rtc_time_t     snap,
    output logic          hold,
    output logic          load,
    output rtc_time_t     load_val
);
    typedef struct packed {
        logic [NUM_TK-1:0][7:0]  snap;
        logic                    hold;
        logic                    touched;
        logic [STORE_N-1:0][7:0] store;
    } reg_state_t;

    reg_state_t    st_d, st_q;
    logic [AW-1:0] sidx;
    logic          is_tk;
    logic [7:0]    rbyte;

    assign sidx  = addr - TK_LIMIT;
    assign is_tk = (addr < TK_LIMIT);

    always_comb begin
        st_d = st_q;
        if (cyc_start && !st_q.hold) begin
            st_d.snap = live;
        end
        if (wr) begin
            if (is_tk) begin
                st_d.snap[addr[TKW-1:0]] = wdata;
                st_d.touched = 1'b1;
            end else begin
                st_d.store[sidx] = wdata;
                if (addr == HOLD_ADDR) begin
                    st_d.hold = wdata[HOLD_BIT];
                end
            end
        end
        if (pwr_fail) begin
            st_d.snap = live;
            st_d.hold = 1'b1;
        end
        load     = cyc_end && st_d.touched;
        load_val = rtc_time_t'(st_d.snap);
        if (cyc_end) begin
            st_d.touched = 1'b0;
        end
    end

    always_comb begin
        rbyte = 8'h00;
        if (rd) begin
            if (is_tk) begin
                rbyte = st_q.snap[addr[TKW-1:0]];
            end else begin
                rbyte = st_q.store[sidx];
                if (addr == HOLD_ADDR) begin
                    rbyte[HOLD_BIT] = st_q.hold;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.snap    <= RTC_EPOCH;
            st_q.hold    <= 1'b0;
            st_q.touched <= 1'b0;
            st_q.store   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = rbyte;
    assign snap  = rtc_time_t'(st_q.snap);
    assign hold  = st_q.hold;
endmodule

// File: rtl/rtc_xfer_core.sv
module rtc_xfer_core
    import rtc_xfer_pkg::*;
#(
    parameter int CLK_PER_TICK = 100000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_fail,
    input  logic [4:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       bus_rd,
    input  logic       bus_wr,
    input  logic       bus_start,
    input  logic       bus_end
);
    localparam int PW = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1;

    rtc_time_t     live, snap, load_val;
    logic          hold, load, tick;
    logic [PW-1:0] presc_cnt;

    rtc_prescaler #(.CLK_PER_TICK(CLK_PER_TICK)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (load),
        .tick  (tick),
        .cnt   (presc_cnt)
    );

    rtc_tk_counter u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (load),
        .load_val (load_val),
        .now      (live)
    );

    rtc_xfer_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_fail  (pwr_fail),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .rd        (bus_rd),
        .wr        (bus_wr),
        .cyc_start (bus_start),
        .cyc_end   (bus_end),
        .live      (live),
        .rdata     (bus_rdata),
        .snap      (snap),
        .hold      (hold),
        .load      (load),
        .load_val  (load_val)
    );
endmodule

// File: rtl/rtc_xfer_core_chk.sv
module rtc_xfer_core_chk
    import rtc_xfer_pkg::*;
#(
    parameter int CLK_PER_TICK = 100000,
    localparam int PW = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pwr_fail,
    input logic [4:0]    bus_addr,
    input logic [7:0]    bus_rdata,
    input logic          bus_rd,
    input logic          bus_wr,
    input logic          bus_start,
    input logic          hold,
    input logic          load,
    input rtc_time_t     live,
    input rtc_time_t     snap,
    input rtc_time_t     load_val,
    input logic [PW-1:0] presc_cnt
);
    // R2
    presc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        presc_cnt <= PW'(CLK_PER_TICK - 1));

    // R9
    divider_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (presc_cnt == '0));

    // R8
    full_transfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (live == $past(load_val)));

    // R5
    start_refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_start && !hold && !pwr_fail && !bus_wr) |=> (snap == $past(live)));

    // R7
    frozen_snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !pwr_fail && !bus_wr) |=> $stable(snap));

    // R6
    pwrfail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |=> hold);

    // R7
    hold_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold) |-> $past(pwr_fail || (bus_wr && bus_addr == 5'h0C)));

    // R11
    idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == 8'h00));
endmodule

bind rtc_xfer_core rtc_xfer_core_chk #(.CLK_PER_TICK(CLK_PER_TICK)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_fail  (pwr_fail),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_start (bus_start),
    .hold      (hold),
    .load      (load),
    .live      (live),
    .snap      (snap),
    .load_val  (load_val),
    .presc_cnt (presc_cnt)
);

// File: tb/rtc_xfer_core_test.sv
module rtc_xfer_core_test;
    localparam int PER = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_fail = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_start = 1'b0;
    logic       bus_end = 1'b0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    logic [63:0] base;
    int          base_edge;
    bit          halted = 0;
    logic [63:0] frozen;
    logic [7:0]  mirror [8:31];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rtc_xfer_core #(.CLK_PER_TICK(PER)) uut (
        .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_start(bus_start), .bus_end(bus_end)
    );

    // ---- reference model in plain integers ----
    function automatic int b2i(input logic [7:0] v);
        return int'(v[7:4]) * 10 + int'(v[3:0]);
    endfunction

    function automatic logic [7:0] i2b(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic int mdays(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    function automatic logic [63:0] mk(input int hu, input int s, input int mi, input int h,
                                       input int dw, input int dt, input int mo, input int y);
        return {i2b(y), i2b(mo), i2b(dt), i2b(dw), i2b(h), i2b(mi), i2b(s), i2b(hu)};
    endfunction

    function automatic logic [63:0] advance(input logic [63:0] t, input int n);
        int hu = b2i(t[7:0]);
        int s  = b2i(t[15:8]);
        int mi = b2i(t[23:16]);
        int h  = b2i(t[31:24]);
        int dw = b2i(t[39:32]);
        int dt = b2i(t[47:40]);
        int mo = b2i(t[55:48]);
        int y  = b2i(t[63:56]);
        for (int k = 0; k < n; k++) begin
            hu++;
            if (hu == 100) begin
                hu = 0; s++;
                if (s == 60) begin
                    s = 0; mi++;
                    if (mi == 60) begin
                        mi = 0; h++;
                        if (h == 24) begin
                            h = 0;
                            dw = (dw % 7) + 1;
                            dt++;
                            if (dt > mdays(mo, y)) begin
                                dt = 1; mo++;
                                if (mo > 12) begin
                                    mo = 1;
                                    y = (y + 1) % 100;
                                end
                            end
                        end
                    end
                end
            end
        end
        return mk(hu, s, mi, h, dw, dt, mo, y);
    endfunction

    function automatic logic [63:0] live_at(input int edge_n);
        return advance(base, (edge_n - 1 - base_edge) / PER);
    endfunction

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    // ---- bus tasks ----
    task automatic set_time(input logic [63:0] t);
        @(negedge clk) bus_start = 1'b1;
        @(negedge clk) bus_start = 1'b0; bus_wr = 1'b1;
        for (int i = 0; i < 8; i++) begin
            bus_addr = 5'(i); bus_wdata = t[8*i +: 8];
            @(negedge clk);
        end
        bus_wr = 1'b0; bus_end = 1'b1;
        base = t; base_edge = cyc + 1;
        if (halted) frozen = t;
        @(negedge clk) bus_end = 1'b0;
    endtask

    task automatic write_byte(input logic [4:0] a, input logic [7:0] d);
        int s;
        int e;
        logic [63:0] b;
        @(negedge clk) bus_start = 1'b1; s = cyc + 1;
        @(negedge clk) bus_start = 1'b0; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk) bus_wr = 1'b0; bus_end = 1'b1; e = cyc + 1;
        @(negedge clk) bus_end = 1'b0;
        if (a < 5'd8) begin
            b = halted ? frozen : live_at(s);
            b[8*a +: 8] = d;
            base = b; base_edge = e;
            if (halted) frozen = b;
        end else begin
            mirror[a] = d;
            if (a == 5'h0C) begin
                if (!halted && d[6]) frozen = live_at(s);
                halted = d[6];
            end
        end
    endtask

    task automatic read_time(output logic [63:0] got, output int s);
        @(negedge clk) bus_start = 1'b1; s = cyc + 1;
        @(negedge clk) bus_start = 1'b0; bus_rd = 1'b1;
        for (int i = 0; i < 8; i++) begin
            bus_addr = 5'(i);
            #1 got[8*i +: 8] = bus_rdata;
            @(negedge clk);
        end
        bus_rd = 1'b0; bus_end = 1'b1;
        @(negedge clk) bus_end = 1'b0;
    endtask

    task automatic read_byte(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk) bus_start = 1'b1;
        @(negedge clk) bus_start = 1'b0; bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk) bus_rd = 1'b0; bus_end = 1'b1;
        @(negedge clk) bus_end = 1'b0;
    endtask

    task automatic check_time(input string req);
        logic [63:0] got;
        int s;
        read_time(got, s);
        chk(req, got, halted ? frozen : live_at(s));
    endtask

    function automatic logic [63:0] corner_time(input int kind);
        int hu = 90 + int'($urandom % 10);
        case (kind)
            0: return mk(hu, 59, 59, 23, 7, 31, 12, 99);
            1: return mk(hu, 59, 59, 23, 3, 28, 2, 24);
            2: return mk(hu, 59, 59, 23, 4, 28, 2, 23);
            3: return mk(hu, 59, 59, 23, 2, 29, 2, 0);
            4: return mk(hu, 59, 59, 23, 5, 30, 4, 57);
            5: return mk(hu, 59, 59, 23, 6, 30, 9, 11);
            default: return mk(hu, 59, int'($urandom % 60), int'($urandom % 24),
                               1 + int'($urandom % 7), 1 + int'($urandom % 28),
                               1 + int'($urandom % 12), int'($urandom % 100));
        endcase
    endfunction

    // ---- watchdog ----
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // ---- main sequence ----
    initial begin
        logic [7:0] rb;
        void'($urandom(32'd2718));
        for (int a = 8; a < 32; a++) mirror[a] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        base = mk(0, 0, 0, 0, 1, 1, 1, 0);
        base_edge = cyc;

        // R1: reset contents
        check_time("R1 time after reset");
        read_byte(5'h0C, rb);
        chk("R1 hold register after reset", {56'd0, rb}, 64'h0);
        read_byte(5'h15, rb);
        chk("R1 storage after reset", {56'd0, rb}, 64'h0);

        // R11: idle read data
        @(negedge clk) bus_addr = 5'h03;
        #1 chk("R11 rdata with strobe low", {56'd0, bus_rdata}, 64'h0);

        // R2 R3 R4: boundary times, random waits
        for (int n = 0; n < 30; n++) begin
            set_time(corner_time(n % 7));
            repeat (int'($urandom % 220)) @(negedge clk);
            check_time("R2 R3 R4 R5 rollover read");
        end

        // R8 R9: single byte writes at random prescaler phase
        for (int n = 0; n < 10; n++) begin
            set_time(corner_time(6));
            repeat (int'($urandom % 23)) @(negedge clk);
            write_byte(5'h01, i2b(int'($urandom % 60)));
            repeat (int'($urandom % 40)) @(negedge clk);
            check_time("R8 R9 partial write reloads all bytes");
        end

        // R9: storage-only writes leave prescaler and time alone
        set_time(corner_time(0));
        repeat (2) @(negedge clk);
        write_byte(5'h09, 8'hA5);
        write_byte(5'h1F, 8'h3C);
        repeat (5) @(negedge clk);
        check_time("R9 storage write keeps prescaler");

        // R6 R7: power-fail snapshot
        set_time(corner_time(1));
        repeat (11) @(negedge clk);
        @(negedge clk) pwr_fail = 1'b1;
        frozen = live_at(cyc + 1); halted = 1;
        @(negedge clk) pwr_fail = 1'b0;
        repeat (37) @(negedge clk);
        check_time("R6 snapshot at power fail");
        read_byte(5'h0C, rb);
        chk("R6 hold flag set", {63'd0, rb[6]}, 64'd1);
        repeat (90) @(negedge clk);
        check_time("R7 snapshot stays frozen");
        write_byte(5'h0D, 8'h40);
        read_byte(5'h0C, rb);
        chk("R7 hold flag unaffected by other writes", {63'd0, rb[6]}, 64'd1);

        // R8 stale corner: write seconds while hold flag set
        write_byte(5'h01, 8'h35);
        repeat (20) @(negedge clk);
        check_time("R8 frozen buffer with new seconds");
        write_byte(5'h0C, 8'h00);
        read_byte(5'h0C, rb);
        chk("R7 hold flag cleared by user", {63'd0, rb[6]}, 64'd0);
        repeat (30) @(negedge clk);
        check_time("R7 R8 stale bytes loaded into counters");

        // R10: storage read/write
        for (int n = 0; n < 40; n++) begin
            logic [4:0] a;
            logic [7:0] d;
            a = 5'(8 + ($urandom % 24));
            d = 8'($urandom);
            if (a == 5'h0C) d[6] = 1'b0;
            write_byte(a, d);
        end
        for (int a = 8; a < 32; a++) begin
            read_byte(5'(a), rb);
            chk("R10 storage readback", {56'd0, rb}, {56'd0, mirror[a]});
        end
        check_time("R9 R10 time after storage traffic");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule